// File: doc/BRIEF.md
# Prescaled Capture Timer

This block is a free-running up-counter for timestamping external events. A power-of-two prescaler derives the count rate from the bus clock. The counter climbs to a programmable modulo limit, then restarts at zero. Each of two capture channels watches one input pin. When the pin shows the edge chosen for that channel, the channel copies the counter into its capture register, sets a flag and can raise an interrupt request.

Software reaches everything through a byte-wide port. Writes are synchronous. Reads are combinational from the address, and the read strobe matters only for arming the flag-clear handshake. Pins are asynchronous and each passes through a two-flop synchroniser before edge detection.

Top module: `capture_timer`

## Requirements
- R1: Control register (address 0) bits [2:0] pick the count rate. Code n in 0..6 advances the counter once every 2^n bus clocks, and code 7 behaves like code 6 (once every 64 clocks).
- R2: On each count tick the counter adds one. A tick that arrives while the counter equals the 16-bit modulo value sets it to 0x0000 instead.
- R3: After reset, the control byte reads 0x00, both modulo bytes read 0xFF, both channel status bytes read 0x00 and both interrupt requests are low.
- R4: A pin level change that is present before clock edge N loads the capture register with the counter value held between edges N+1 and N+2. The flag reads 1 after edge N+2. At divide-by-1 this value is the count read just before edge N plus 2.
- R5: Status bits [3:2] select the capture edge: 00 none, 01 rising, 10 falling, 11 both. An edge that is not selected leaves the flag and the capture register unchanged.
- R6: Status byte layout, bit 7 down to 0: flag, interrupt enable, mode B, mode A, edge B, edge A, toggle, max. Bits 6..0 read back as written, except that channel 1 bit 5 always reads 0.
- R7: The flag is cleared only by a status write with bit 7 = 0 that follows a status read made while the flag was 1. A write of 0 without that read leaves the flag set. Writing 1 never sets it.
- R8: irq[i] is high exactly while channel i has both its flag and its interrupt enable (bit 6) set.
- R9: Address map: 0 control, 1/2 count high/low (read only), 3/4 modulo high/low, channel i at 5+3i (status), 6+3i (capture high), 7+3i (capture low). Unused addresses read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 4 | Register address |
| wr_en | input | 1 | Write strobe, acts at the rising clock edge |
| wdata | input | 8 | Write data |
| rd_en | input | 1 | Read strobe, arms flag clearing |
| rdata | output | 8 | Read data, combinational from addr |
| cap_pin | input | 2 | Asynchronous capture inputs, one per channel |
| irq | output | 2 | Interrupt request per channel |

## Verification
A capture result arrives three rising edges after the pin change. Two of those edges are the synchroniser and the third is the capture latch. The bench therefore changes a pin just after a falling edge, waits three rising edges and samples on the next falling edge. It compares against the count it read in the same half-cycle as the pin change, plus two.

Register writes take effect at the single rising edge inside the write task. Reads are sampled a nanosecond after the address settles, with no edge in between, so both count bytes come from the same instant. Rate checks compare count differences across windows of 8 × 2^n clocks, and each such window must hold exactly 8 ticks.

// File: rtl/cap_tmr_pkg.sv
package cap_tmr_pkg;

    localparam int CNT_W     = 16;
    localparam int ADDR_W    = 4;
    localparam int CH_BASE   = 5;
    localparam int CH_STRIDE = 3;

    localparam logic [ADDR_W-1:0] A_CTRL  = 4'd0;
    localparam logic [ADDR_W-1:0] A_CNT_H = 4'd1;
    localparam logic [ADDR_W-1:0] A_CNT_L = 4'd2;
    localparam logic [ADDR_W-1:0] A_MOD_H = 4'd3;
    localparam logic [ADDR_W-1:0] A_MOD_L = 4'd4;

    // Channel status byte; field order is visible to software.
    typedef struct packed {
        logic flag;
        logic ie;
        logic mode_b;
        logic mode_a;
        logic edge_b;
        logic edge_a;
        logic tog;
        logic cmax;
    } ch_stat_t;

endpackage

// File: rtl/cap_tmr_prescale.sv
module cap_tmr_prescale #(
    parameter int PS_W  = 3,
    parameter int DIV_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PS_W-1:0] ps_sel,
    output logic            tick
);

    typedef struct packed {
        logic [DIV_W-1:0] div;
    } pre_state_t;

    pre_state_t       pre_q, pre_d;
    logic [DIV_W-1:0] mask;
    int               rate;

    always_comb begin
        // Codes above the divider width saturate at the slowest rate.
        rate = (int'(ps_sel) > DIV_W) ? DIV_W : int'(ps_sel);
        mask = '0;
        for (int b = 0; b < DIV_W; b++) begin
            if (b < rate) mask[b] = 1'b1;
        end
        tick       = &(pre_q.div | ~mask);
        pre_d      = pre_q;
        pre_d.div  = pre_q.div + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    assert_div1_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (ps_sel == '0) |-> tick);

    assert_slow_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && ps_sel != '0) |=> (!tick || ps_sel == '0));

endmodule

// File: rtl/cap_tmr_counter.sv
module cap_tmr_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] mod_val,
    output logic [CNT_W-1:0] count
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (tick) begin
            if (cnt_q.cnt == mod_val) cnt_d.cnt = '0;
            else                      cnt_d.cnt = cnt_q.cnt + 1'b1;
        end
        count = cnt_q.cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && count == mod_val) |=> (count == '0));

    assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && count != mod_val) |=> (count == $past(count) + 1'b1));

    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(count));

endmodule

// File: rtl/cap_tmr_channel.sv
module cap_tmr_channel
    import cap_tmr_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter bit HAS_MSB = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin,
    input  logic [CNT_W-1:0] count,
    input  logic             st_wr,
    input  logic             st_rd,
    input  logic [7:0]       wdata,
    output ch_stat_t         status,
    output logic [CNT_W-1:0] cap,
    output logic             irq
);

    typedef struct packed {
        logic [1:0]       sync;
        logic             prev;
        ch_stat_t         st;
        logic             arm;
        logic [CNT_W-1:0] cap;
    } ch_state_t;

    ch_state_t ch_q, ch_d;
    logic      rise, fall, hit;

    always_comb begin
        ch_d      = ch_q;
        ch_d.sync = {ch_q.sync[0], pin};
        ch_d.prev = ch_q.sync[1];

        rise = ch_q.sync[1] & ~ch_q.prev;
        fall = ~ch_q.sync[1] & ch_q.prev;
        hit  = (ch_q.st.edge_a & rise) | (ch_q.st.edge_b & fall);

        if (st_wr) begin
            ch_d.st.ie     = wdata[6];
            ch_d.st.mode_b = HAS_MSB ? wdata[5] : 1'b0;
            ch_d.st.mode_a = wdata[4];
            ch_d.st.edge_b = wdata[3];
            ch_d.st.edge_a = wdata[2];
            ch_d.st.tog    = wdata[1];
            ch_d.st.cmax   = wdata[0];
            ch_d.arm       = 1'b0;
            if (ch_q.arm && !wdata[7]) ch_d.st.flag = 1'b0;
        end else if (st_rd && ch_q.st.flag) begin
            ch_d.arm = 1'b1;
        end

        // A capture in the same cycle as a clear keeps the flag set.
        if (hit) begin
            ch_d.st.flag = 1'b1;
            ch_d.cap     = count;
        end

        status = ch_q.st;
        cap    = ch_q.cap;
        irq    = ch_q.st.flag & ch_q.st.ie;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ch_q <= '0;
        else        ch_q <= ch_d;
    end

    assert_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (status.flag && cap == $past(count)));

    assert_edge_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ch_q.st.edge_a && !ch_q.st.edge_b) |=> $stable(cap));

    assert_no_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> !$rose(status.flag));

    assert_unarmed_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_wr && !ch_q.arm && ch_q.st.flag) |=> status.flag);

endmodule

// File: rtl/capture_timer.sv
module capture_timer
    import cap_tmr_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int PS_W   = 3,
    parameter int DIV_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [7:0]        wdata,
    input  logic              rd_en,
    output logic [7:0]        rdata,
    input  logic [NUM_CH-1:0] cap_pin,
    output logic [NUM_CH-1:0] irq
);

    typedef struct packed {
        logic [PS_W-1:0]  ps;
        logic [CNT_W-1:0] mod;
    } reg_state_t;

    reg_state_t       rg_q, rg_d;
    logic             tick;
    logic [CNT_W-1:0] count;
    ch_stat_t         ch_status [NUM_CH];
    logic [CNT_W-1:0] ch_cap    [NUM_CH];

    always_comb begin
        rg_d = rg_q;
        if (wr_en) begin
            case (addr)
                A_CTRL:  rg_d.ps         = wdata[PS_W-1:0];
                A_MOD_H: rg_d.mod[15:8]  = wdata;
                A_MOD_L: rg_d.mod[7:0]   = wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rg_q.ps  <= '0;
            rg_q.mod <= '1;
        end else begin
            rg_q <= rg_d;
        end
    end

    cap_tmr_prescale #(.PS_W(PS_W), .DIV_W(DIV_W)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .ps_sel (rg_q.ps),
        .tick   (tick)
    );

    cap_tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .mod_val (rg_q.mod),
        .count   (count)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        localparam logic [ADDR_W-1:0] ST_ADDR = ADDR_W'(CH_BASE + CH_STRIDE * i);
        cap_tmr_channel #(.CNT_W(CNT_W), .HAS_MSB(i == 0)) u_ch (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin    (cap_pin[i]),
            .count  (count),
            .st_wr  (wr_en && addr == ST_ADDR),
            .st_rd  (rd_en && addr == ST_ADDR),
            .wdata  (wdata),
            .status (ch_status[i]),
            .cap    (ch_cap[i]),
            .irq    (irq[i])
        );
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL:  rdata = 8'(rg_q.ps);
            A_CNT_H: rdata = count[15:8];
            A_CNT_L: rdata = count[7:0];
            A_MOD_H: rdata = rg_q.mod[15:8];
            A_MOD_L: rdata = rg_q.mod[7:0];
            default: ;
        endcase
        for (int i = 0; i < NUM_CH; i++) begin
            if (addr == ADDR_W'(CH_BASE + CH_STRIDE * i))     rdata = ch_status[i];
            if (addr == ADDR_W'(CH_BASE + CH_STRIDE * i + 1)) rdata = ch_cap[i][15:8];
            if (addr == ADDR_W'(CH_BASE + CH_STRIDE * i + 2)) rdata = ch_cap[i][7:0];
        end
    end

    assert_mod_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en) |=> $stable(rg_q.mod));

endmodule

// File: tb/capture_timer_test.sv
`timescale 1ns/1ps
module capture_timer_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] addr = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wdata = '0;
    logic       rd_en = 1'b0;
    logic [7:0] rdata;
    logic [1:0] cap_pin = 2'b00;
    logic [1:0] irq;

    int errs = 0;
    int checks = 0;

    capture_timer uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
        .rd_en(rd_en), .rdata(rdata), .cap_pin(cap_pin), .irq(irq)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic peek(input logic [3:0] a, output logic [7:0] d);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic peek_cnt(output logic [15:0] c);
        logic [7:0] h, l;
        peek(4'd1, h);
        peek(4'd2, l);
        c = {h, l};
    endtask

    initial begin
        logic [7:0]  b, hb, lb;
        logic [15:0] c0, c1, prev, old_cap;
        int          wraps;

        do_reset();
        @(negedge clk);
        // R3: reset state
        peek(4'd0, b); chk("R3 ctrl", b, 8'h00);
        peek(4'd3, b); chk("R3 mod hi", b, 8'hFF);
        peek(4'd4, b); chk("R3 mod lo", b, 8'hFF);
        peek(4'd5, b); chk("R3 status0", b, 8'h00);
        peek(4'd8, b); chk("R3 status1", b, 8'h00);
        chk("R3 irq", irq, 0);
        peek(4'd15, b); chk("R9 unused addr", b, 8'h00);

        // R1: rate sweep over every prescaler code
        for (int ps = 0; ps < 8; ps++) begin
            int div;
            div = 1 << ((ps > 6) ? 6 : ps);
            wr(4'd0, 8'(ps));
            @(negedge clk);
            peek_cnt(c0);
            repeat (div * 8) @(negedge clk);
            peek_cnt(c1);
            chk($sformatf("R1 ps=%0d ticks", ps), 16'(c1 - c0), 8);
        end
        wr(4'd0, 8'h00);

        // R4/R5/R8: sweep edge codes and both directions on both channels
        for (int ch = 0; ch < 2; ch++) begin
            logic [3:0] base;
            base = 4'(5 + 3 * ch);
            for (int code = 0; code < 4; code++) begin
                for (int dir = 0; dir < 2; dir++) begin
                    logic [7:0] cfg;
                    logic       match;
                    cfg = 8'h40 | 8'(code << 2);
                    cap_pin[ch] = ~dir[0];
                    repeat (4) @(negedge clk);
                    wr(base, cfg);
                    rd(base, b);
                    wr(base, cfg);
                    @(negedge clk);
                    peek(base, b);
                    chk("R7 flag cleared before edge", b[7], 0);
                    peek(base + 4'd1, hb);
                    peek(base + 4'd2, lb);
                    old_cap = {hb, lb};
                    peek_cnt(c0);
                    cap_pin[ch] = dir[0];
                    repeat (3) @(posedge clk);
                    @(negedge clk);
                    match = (code[0] & dir[0]) | (code[1] & ~dir[0]);
                    peek(base, b);
                    chk($sformatf("R5 ch%0d code%0d dir%0d flag", ch, code, dir), b[7], match);
                    peek(base + 4'd1, hb);
                    peek(base + 4'd2, lb);
                    chk($sformatf("R4 ch%0d code%0d dir%0d cap", ch, code, dir),
                        {hb, lb}, match ? 16'(c0 + 16'd2) : old_cap);
                    chk($sformatf("R8 ch%0d irq", ch), irq[ch], match);
                end
            end
        end

        // R7: flag clear handshake on channel 0 (rising edge, enabled)
        cap_pin[0] = 1'b0;
        repeat (4) @(negedge clk);
        wr(4'd5, 8'h44); rd(4'd5, b); wr(4'd5, 8'h44);
        cap_pin[0] = 1'b1;
        repeat (4) @(negedge clk);
        peek(4'd5, b); chk("R7 flag set by edge", b[7], 1);
        wr(4'd5, 8'h44);
        peek(4'd5, b); chk("R7 write 0 without read keeps flag", b[7], 1);
        wr(4'd5, 8'hC4);
        peek(4'd5, b); chk("R7 write 1 keeps flag", b[7], 1);
        rd(4'd5, b);
        wr(4'd5, 8'h44);
        peek(4'd5, b); chk("R7 read then write 0 clears", b[7], 0);
        chk("R8 irq low after clear", irq[0], 0);
        wr(4'd5, 8'hC4);
        peek(4'd5, b); chk("R7 write 1 does not set", b[7], 0);

        // R8: flag set while disabled, then enable
        wr(4'd5, 8'h04);
        cap_pin[0] = 1'b0;
        repeat (4) @(negedge clk);
        cap_pin[0] = 1'b1;
        repeat (4) @(negedge clk);
        peek(4'd5, b); chk("R8 flag set with ie=0", b[7], 1);
        chk("R8 irq masked", irq[0], 0);
        wr(4'd5, 8'h44);
        chk("R8 irq on enable", irq[0], 1);

        // R6: status layout and readback
        rd(4'd5, b);
        wr(4'd5, 8'h3F);
        peek(4'd5, b); chk("R6 ch0 readback", b, 8'h3F);
        rd(4'd8, b);
        wr(4'd8, 8'h7F);
        peek(4'd8, b); chk("R6 ch1 bit5 zero", b, 8'h5F);

        // R2: modulo wrap with a small limit
        do_reset();
        wr(4'd4, 8'd20);
        wr(4'd3, 8'd0);
        peek(4'd3, hb); peek(4'd4, lb);
        chk("R9 modulo readback", {hb, lb}, 16'd20);
        wraps = 0;
        peek_cnt(prev);
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            peek_cnt(c1);
            chk("R2 next count", c1, (prev == 16'd20) ? 0 : int'(prev) + 1);
            if (prev == 16'd20 && c1 == 16'd0) wraps++;
            prev = c1;
        end
        chk("R2 wraps seen", wraps >= 2, 1);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        #(20 * 200000);
        errs++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule